// File: doc/BRIEF.md
# Cascadable Signed/Unsigned Compare Unit

This block compares a 96-bit register operand against either a second register operand or a 20-bit immediate placed at a chosen 20-bit step. A single operation yields the equal, unsigned-less-than and signed-less-than outcomes together. The result lands in one of eight six-flag condition fields, so one compare opcode serves both signed and unsigned code.

A constant wider than one immediate can be matched across several instructions. The first compare checks the top slice of the constant and every bit above it. Each later cascaded compare checks the next lower 20-bit slice. A cascaded compare only acts when its target field still reads equal. The first slice that differs therefore fixes the ordering, and the remaining cascaded compares leave the field alone.

An operation is offered on a valid strobe. Its flags are visible on the field bank one clock later.

Top module: `cascade_cmp_unit`

## Requirements
- R1: Reset (synchronous, active low) clears all eight condition fields to zero. Each field is 6 bits wide and field n occupies bank bits [6n+5:6n]. Within a field, bit 0 is cf, bit 1 is vf, bit 2 is nf, bit 3 is zf, bit 4 is sf and bit 5 is so.
- R2: A non-cascaded compare of x against y sets the following flags: zf when x equals y, cf when x is unsigned less than y, and nf when x is signed less than y. It sets sf equal to nf.
- R3: A non-cascaded compare sets vf when the two's-complement difference x-y overflows. It ORs vf into so, and so stays set until reset.
- R4: The target field is updated on the first rising edge after a valid operation. No other field changes at that edge, and no field changes when op_valid is low.
- R5: In the immediate form, the immediate sits at bit position 20*op_shift, with op_shift ranging from 0 to 7. Immediate bits that land above bit 95 are dropped, and operand bits below the window are ignored. A non-cascaded immediate compare also compares the operand bits above the window against zero.
- R6: A cascaded compare whose target field has zf clear changes nothing.
- R7: A cascaded compare whose target field has zf set compares without sign. In the immediate form it compares only the window bits; in the register form it compares the whole operands. It writes zf from equality and writes nf, cf and sf from the unsigned less-than result. It keeps vf and so unchanged.
- R8: In a chain of cascaded compares, the first non-equal slice decides the final ordering in nf, cf and sf. All later cascaded compares are no-ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Operation valid strobe |
| op_cascade | input | 1 | Cascaded compare |
| op_use_imm | input | 1 | Compare against shifted immediate instead of op_b |
| op_field | input | 3 | Destination condition field index |
| op_a | input | 96 | First operand |
| op_b | input | 96 | Second register operand |
| op_imm | input | 20 | Immediate value |
| op_shift | input | 3 | Immediate position in 20-bit steps |
| cr_bank | output | 48 | All eight condition fields |

## Verification
On every cycle, the assertions check four properties. No field moves while the unit is idle, and a gated cascaded compare leaves the bank untouched. A written field never shows equal together with either less-than flag. The summary-overflow flag never falls and always covers the overflow flag. Only the bench scenarios can show the flag values themselves. This covers operand sign corners, overflow, window placement at each shift step, discarded immediate bits, and a multi-slice chain whose outcome is decided mid-way.

// File: rtl/cmp_pkg.sv
// Shared widths and the condition-field layout for the compare unit.
// Assumes one field per destination index; flag order is fixed by R1.
package cmp_pkg;
    localparam int DATA_W     = 96;
    localparam int IMM_W      = 20;
    localparam int SHIFT_W    = 3;
    localparam int NUM_FIELDS = 8;
    localparam int IDX_W      = $clog2(NUM_FIELDS);

    // bit 5 so, 4 sf, 3 zf, 2 nf, 1 vf, 0 cf
    typedef struct packed {
        logic so;
        logic sf;
        logic zf;
        logic nf;
        logic vf;
        logic cf;
    } cr_flags_t;

    localparam int FLAG_W = $bits(cr_flags_t);
endpackage

// File: rtl/cmp_operand_sel.sv
// Builds the two compare operands x and y.
// Register form: x = a, y = b.
// Immediate form: the immediate is placed at bit 20*shift. Bits past the top are dropped.
// A first compare keeps a's bits at and above the window; a cascaded compare keeps only
// the window. Bits below the window are zero on both sides.
// Purely combinational.
module cmp_operand_sel #(
    parameter int DATA_W  = 96,
    parameter int IMM_W   = 20,
    parameter int SHIFT_W = 3
) (
    input  logic [DATA_W-1:0]  a,
    input  logic [DATA_W-1:0]  b,
    input  logic               use_imm,
    input  logic               cascade,
    input  logic [IMM_W-1:0]   imm,
    input  logic [SHIFT_W-1:0] shift,
    output logic [DATA_W-1:0]  x,
    output logic [DATA_W-1:0]  y
);
    localparam int LIM = DATA_W + IMM_W;

    // Per-bit window decode and immediate placement.
    always_comb begin
        int lo;
        logic [IMM_W-1:0] moved;
        lo = int'(shift) * IMM_W;
        x  = '0;
        y  = '0;
        for (int i = 0; i < DATA_W; i++) begin
            logic above;
            logic inwin;
            above = (i >= lo);
            inwin = above && (i < lo + IMM_W) && (lo < LIM);
            moved = above ? (imm >> (i - lo)) : '0;
            if (!use_imm) begin
                x[i] = a[i];
                y[i] = b[i];
            end else begin
                x[i] = a[i] & (cascade ? inwin : above);
                y[i] = inwin & moved[0];
            end
        end
    end
endmodule

// File: rtl/cmp_core.sv
// Subtract-based magnitude compare of x against y.
// Produces equality, unsigned and signed less-than, and signed overflow of x-y in one pass.
// Purely combinational.
module cmp_core #(
    parameter int DATA_W = 96
) (
    input  logic [DATA_W-1:0] x,
    input  logic [DATA_W-1:0] y,
    output logic              eq,
    output logic              lt_u,
    output logic              lt_s,
    output logic              ovf
);
    logic [DATA_W:0] diff;
    logic            sx;
    logic            sy;

    // One wide subtraction feeds all orderings.
    always_comb begin
        diff = {1'b0, x} - {1'b0, y};
        sx   = x[DATA_W-1];
        sy   = y[DATA_W-1];
        eq   = (x == y);
        lt_u = diff[DATA_W];
        lt_s = (sx != sy) ? sx : diff[DATA_W-1];
        ovf  = (sx != sy) && (diff[DATA_W-1] != sx);
    end
endmodule

// File: rtl/cmp_flag_bank.sv
// Holds the condition fields and applies the write and cascade-gating rules.
// Assumes one operation per cycle. A write lands on the edge after op_valid.
module cmp_flag_bank
    import cmp_pkg::*;
#(
    parameter int NFIELD = 8,
    parameter int IW     = $clog2(NFIELD)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     valid,
    input  logic                     cascade,
    input  logic [IW-1:0]            idx,
    input  logic                     eq,
    input  logic                     lt_u,
    input  logic                     lt_s,
    input  logic                     ovf,
    output logic [NFIELD*FLAG_W-1:0] bank
);
    cr_flags_t fields [NFIELD];
    cr_flags_t cur;
    cr_flags_t nxt;
    logic      gated;
    logic      wr;

    // Select the target field and form its next value.
    always_comb begin
        cur   = fields[idx];
        gated = cascade && !cur.zf;
        wr    = valid && !gated;
        if (cascade) begin
            nxt = '{so: cur.so, sf: lt_u, zf: eq, nf: lt_u, vf: cur.vf, cf: lt_u};
        end else begin
            nxt = '{so: cur.so | ovf, sf: lt_s, zf: eq, nf: lt_s, vf: ovf, cf: lt_u};
        end
    end

    // Field storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int f = 0; f < NFIELD; f++) fields[f] <= '0;
        end else if (wr) begin
            fields[idx] <= nxt;
        end
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_out
        assign bank[g*FLAG_W +: FLAG_W] = fields[g];

        // R2
        eq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fields[g].zf |-> !(fields[g].nf || fields[g].cf));
        // R3
        so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$fell(fields[g].so));
        // R3
        so_covers_vf_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fields[g].vf |-> fields[g].so);
    end

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(bank));
    // R6
    cascade_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cascade && !cur.zf) |=> $stable(bank));
endmodule

// File: rtl/cascade_cmp_unit.sv
// Top of the compare unit: operand selection, compare and condition field bank.
// One operation may be presented per cycle; results appear one clock later on cr_bank.
module cascade_cmp_unit
    import cmp_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IMW = IMM_W,
    parameter int SW = SHIFT_W,
    parameter int NF = NUM_FIELDS,
    parameter int FW = $clog2(NF)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic                 op_cascade,
    input  logic                 op_use_imm,
    input  logic [FW-1:0]        op_field,
    input  logic [DW-1:0]        op_a,
    input  logic [DW-1:0]        op_b,
    input  logic [IMW-1:0]       op_imm,
    input  logic [SW-1:0]        op_shift,
    output logic [NF*FLAG_W-1:0] cr_bank
);
    logic [DW-1:0] x;
    logic [DW-1:0] y;
    logic          eq;
    logic          lt_u;
    logic          lt_s;
    logic          ovf;

    cmp_operand_sel #(.DATA_W(DW), .IMM_W(IMW), .SHIFT_W(SW)) u_sel (
        .a(op_a), .b(op_b), .use_imm(op_use_imm), .cascade(op_cascade),
        .imm(op_imm), .shift(op_shift), .x(x), .y(y)
    );

    cmp_core #(.DATA_W(DW)) u_core (
        .x(x), .y(y), .eq(eq), .lt_u(lt_u), .lt_s(lt_s), .ovf(ovf)
    );

    cmp_flag_bank #(.NFIELD(NF), .IW(FW)) u_bank (
        .clk(clk), .rst_n(rst_n), .valid(op_valid), .cascade(op_cascade),
        .idx(op_field), .eq(eq), .lt_u(lt_u), .lt_s(lt_s), .ovf(ovf),
        .bank(cr_bank)
    );
endmodule

// File: tb/cascade_cmp_unit_bench.sv
// Vector table walk followed by directed reset and idle tests.
module cascade_cmp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_cascade = 1'b0;
    logic        op_use_imm = 1'b0;
    logic [2:0]  op_field = '0;
    logic [95:0] op_a = '0;
    logic [95:0] op_b = '0;
    logic [19:0] op_imm = '0;
    logic [2:0]  op_shift = '0;
    logic [47:0] cr_bank;

    int checks = 0;
    int fails = 0;
    logic [5:0] model [8];

    always #10 clk = ~clk;

    cascade_cmp_unit u_cascade_cmp_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_cascade(op_cascade),
        .op_use_imm(op_use_imm), .op_field(op_field), .op_a(op_a), .op_b(op_b),
        .op_imm(op_imm), .op_shift(op_shift), .cr_bank(cr_bank)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [95:0] a;
        logic [95:0] b;
        logic        imm_en;
        logic [19:0] imm;
        logic [2:0]  sh;
        logic        casc;
        logic [2:0]  fld;
        logic [5:0]  exp;   // so sf zf nf vf cf
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        // R2 equal registers
        '{4'd2, 96'd5, 96'd5, 1'b0, 20'h0, 3'd0, 1'b0, 3'd0, 6'b001000},
        // R2 small less-than
        '{4'd2, 96'd3, 96'd7, 1'b0, 20'h0, 3'd0, 1'b0, 3'd1, 6'b010101},
        // R2 minus one against one: signed less, unsigned greater
        '{4'd2, 96'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF, 96'd1, 1'b0, 20'h0, 3'd0, 1'b0, 3'd2, 6'b010100},
        // R3 most negative minus one overflows
        '{4'd3, 96'h8000_0000_0000_0000_0000_0000, 96'd1, 1'b0, 20'h0, 3'd0, 1'b0, 3'd3, 6'b110110},
        // R3 so stays set after a clean compare
        '{4'd3, 96'd2, 96'd1, 1'b0, 20'h0, 3'd0, 1'b0, 3'd3, 6'b100000},
        // R5 first slice at step 3 plus bits above
        '{4'd5, 96'h0000_1234_5678_90AB_CDEF_0123, 96'd0, 1'b1, 20'h12345, 3'd3, 1'b0, 3'd4, 6'b001000},
        // R7 cascaded slice equal
        '{4'd7, 96'h0000_1234_5678_90AB_CDEF_0123, 96'd0, 1'b1, 20'h67890, 3'd2, 1'b1, 3'd4, 6'b001000},
        // R8 cascaded slice decides less-than
        '{4'd8, 96'h0000_1234_5678_90AB_CDEF_0123, 96'd0, 1'b1, 20'hABCDF, 3'd1, 1'b1, 3'd4, 6'b010101},
        // R8 later cascaded compare is a no-op
        '{4'd8, 96'h0000_1234_5678_90AB_CDEF_0123, 96'd0, 1'b1, 20'h00000, 3'd0, 1'b1, 3'd4, 6'b010101},
        // R5 bits above window take part in first compare
        '{4'd5, 96'h8000_1234_5678_90AB_CDEF_0123, 96'd0, 1'b1, 20'h12345, 3'd3, 1'b0, 3'd5, 6'b010100},
        // R6 cascade on non-equal field ignored
        '{4'd6, 96'd0, 96'd0, 1'b1, 20'h00000, 3'd0, 1'b1, 3'd5, 6'b010100},
        // R5 step 4: top imm nibble dropped, low operand bits ignored
        '{4'd5, 96'hFFFF_0000_0000_0000_0000_0001, 96'd0, 1'b1, 20'hFFFFF, 3'd4, 1'b0, 3'd6, 6'b001000},
        // R5 step 5 puts the window past the top: equal
        '{4'd5, 96'h1234_5678_9ABC_DEF0_1234_5678, 96'd0, 1'b1, 20'hFFFFF, 3'd5, 1'b0, 3'd7, 6'b001000},
        // R7 cascaded register form, unsigned less
        '{4'd7, 96'd1, 96'd2, 1'b0, 20'h0, 3'd0, 1'b1, 3'd7, 6'b010101},
        // R7 cascaded immediate greater
        '{4'd7, 96'd5, 96'd0, 1'b1, 20'h00001, 3'd0, 1'b1, 3'd0, 6'b000000}
    };

    // Compare the whole bank against the model.
    task automatic check_bank(input string tag);
        logic [47:0] want;
        for (int f = 0; f < 8; f++) want[f*6 +: 6] = model[f];
        checks++;
        if (cr_bank !== want) begin
            fails++;
            $display("FAIL %s: bank actual %h expected %h", tag, cr_bank, want);
        end
    endtask

    // Present one operation for a single cycle, then return after its write edge.
    task automatic issue(input vec_t v);
        @(negedge clk);
        op_valid = 1'b1; op_a = v.a; op_b = v.b; op_use_imm = v.imm_en;
        op_imm = v.imm; op_shift = v.sh; op_cascade = v.casc; op_field = v.fld;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    // Ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        for (int f = 0; f < 8; f++) model[f] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_bank("R1 reset");

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i]);
            model[VEC[i].fld] = VEC[i].exp;
            check_bank($sformatf("R%0d vector %0d", VEC[i].req, i));
        end

        // R4 idle: inputs that would change field 0 but valid low
        @(negedge clk);
        op_valid = 1'b0; op_cascade = 1'b0; op_use_imm = 1'b0;
        op_a = 96'd1; op_b = 96'd9; op_field = 3'd0;
        @(negedge clk);
        @(negedge clk);
        check_bank("R4 idle hold");

        // R4 latency: result not visible before the write edge
        @(negedge clk);
        op_valid = 1'b1; op_a = 96'd1; op_b = 96'd9; op_field = 3'd0; op_cascade = 1'b0;
        check_bank("R4 before edge");
        @(negedge clk);
        op_valid = 1'b0;
        model[0] = 6'b010101;
        check_bank("R4 after edge");

        // R6 cascade to field 3 (zf clear, so set) changes nothing
        issue('{4'd6, 96'd0, 96'd0, 1'b0, 20'h0, 3'd0, 1'b1, 3'd3, 6'b100000});
        check_bank("R6 gated cascade keeps so field");

        // R1 reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int f = 0; f < 8; f++) model[f] = '0;
        check_bank("R1 reset mid-run");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule